// File: doc/BRIEF.md
# Cascaded Fixed-Priority Output Arbiter

This block allocates the three outputs of one half of a mesh router (north-one, east, south-one) among four competing inputs (west, north-one, south-one and the local processing element) within a single clock cycle. Route computation is done elsewhere and arrives as a request matrix: one bit for each output and input pair. The block also receives a service-type flag for each input, the reservation state of each output and the full flag of each output's downstream queue. For each output it produces a select code that drives the crossbar multiplexer in the same cycle.

The outputs are resolved as a chain. North-one picks first, then east, then south-one. Each stage masks out the inputs that were already granted further up the chain. Within one output, a request for multi-flit reserved service beats a single-flit request. Among requests of equal service, a fixed rank list decides. An output that is reserved keeps the select it had in the previous cycle, so body flits keep flowing along the path the head flit set up.

Top module: `cpa_arbiter`

## Requirements
- R1: After synchronous reset, with no requests, every select is idle, and the remembered selects are idle, so an output reserved in the first cycles also shows idle.
- R2: Select code 0 is idle. Codes 1, 2, 3 and 4 pick input W, N1, S1 and PE. Request and flag bit 0 is W, bit 1 is N1, bit 2 is S1 and bit 3 is PE. Output index 0 is N1, 1 is E and 2 is S1. Output N1 never selects input N1, and output S1 never selects input S1.
- R3: Ranks, highest first, among requests of equal service:
  - output N1: W, S1, PE
  - output E: N1, S1, W, PE
  - output S1: N1, W, PE
  The PE input is therefore always last.
- R4: At an output, any requesting input whose block flag is set wins over every requesting input whose flag is clear, whatever their ranks.
- R5: Outputs are resolved in the order N1, E, S1. An input granted at an earlier output in the same cycle is not a candidate for a later output, which then falls to its next candidate.
- R6: No input appears in the select of two outputs in the same cycle.
- R7: A reserved output shows the same select it showed in the previous cycle. It ignores new requests, block flags and its full flag.
- R8: An input held by any reserved output is excluded from new grants on every other output in that cycle.
- R9: A non-reserved output whose full flag is set shows idle. The candidate it would have taken stays available to later outputs.
- R10: The select depends on the present cycle's inputs, with no added latency, and a non-reserved output only selects an input that requests it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 3x4 | Request matrix, indexed [output][input] |
| blk_i | input | 4 | Block-service flag for each input |
| rsv_i | input | 3 | Reservation state for each output |
| full_i | input | 3 | Downstream full flag for each output |
| sel_o | output | 3x3 | Select code for each output, indexed [output] |

## Verification
The sharpest collision is a reserved output holding its input in the same cycle that the other outputs run the cascade for new head flits. The held input must vanish from every candidate set while the reserved output ignores its own requests and full flag. The bench provokes this by granting an input on east, then reserving east while that input and others request north-one and south-one. The expected result is north-one falling to its second-ranked input and south-one going idle. A second overlap, a full output inside the cascade, is judged by checking that the candidate it skipped is picked up by the next output in the same cycle.

// File: rtl/cpa_pkg.sv
package cpa_pkg;

    localparam int N_IN    = 4;
    localparam int N_OUT   = 3;
    localparam int SEL_W   = $clog2(N_IN + 1);
    localparam int NO_RANK = 15;

    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [N_IN-1:0]  in_vec_t;

    localparam sel_t SEL_IDLE = '0;

    typedef enum int {
        IN_W  = 0,
        IN_N1 = 1,
        IN_S1 = 2,
        IN_PE = 3
    } in_id_e;

    typedef enum int {
        OUT_N1 = 0,
        OUT_E  = 1,
        OUT_S1 = 2
    } out_id_e;

    // Rank of input i at output o; 0 is highest, NO_RANK means not allowed.
    function automatic int prio_rank(int o, int i);
        int r;
        r = NO_RANK;
        case (o)
            OUT_N1: begin
                case (i)
                    IN_W:    r = 0;
                    IN_S1:   r = 1;
                    IN_PE:   r = 2;
                    default: r = NO_RANK;
                endcase
            end
            OUT_E: begin
                case (i)
                    IN_N1:   r = 0;
                    IN_S1:   r = 1;
                    IN_W:    r = 2;
                    IN_PE:   r = 3;
                    default: r = NO_RANK;
                endcase
            end
            OUT_S1: begin
                case (i)
                    IN_N1:   r = 0;
                    IN_W:    r = 1;
                    IN_PE:   r = 2;
                    default: r = NO_RANK;
                endcase
            end
            default: r = NO_RANK;
        endcase
        return r;
    endfunction

    function automatic sel_t enc_sel(int i);
        return sel_t'(i + 1);
    endfunction

    function automatic in_vec_t sel_onehot(sel_t s);
        in_vec_t v;
        v = '0;
        for (int i = 0; i < N_IN; i++) begin
            if (s == enc_sel(i)) v[i] = 1'b1;
        end
        return v;
    endfunction

    function automatic logic sel_legal(int o, sel_t s);
        logic ok;
        ok = (s == SEL_IDLE);
        for (int i = 0; i < N_IN; i++) begin
            if (s == enc_sel(i) && prio_rank(o, i) != NO_RANK) ok = 1'b1;
        end
        return ok;
    endfunction

endpackage

// File: rtl/cpa_stage.sv
module cpa_stage
    import cpa_pkg::*;
#(
    parameter int OUT_IDX = 0
) (
    input  logic    clk,
    input  logic    rst,
    input  in_vec_t req,
    input  in_vec_t blk,
    input  logic    rsv,
    input  logic    full,
    input  sel_t    held,
    input  in_vec_t taken_in,
    output sel_t    sel,
    output in_vec_t taken_out
);

    in_vec_t cand;
    sel_t    pick_blk;
    sel_t    pick_sgl;

    always_comb begin
        cand = req & ~taken_in;
        for (int i = 0; i < N_IN; i++) begin
            if (prio_rank(OUT_IDX, i) == NO_RANK) cand[i] = 1'b0;
        end
    end

    // Scan ranks from lowest to highest so the best candidate is written last.
    always_comb begin
        pick_blk = SEL_IDLE;
        pick_sgl = SEL_IDLE;
        for (int r = N_IN - 1; r >= 0; r--) begin
            for (int i = 0; i < N_IN; i++) begin
                if (cand[i] && prio_rank(OUT_IDX, i) == r) begin
                    if (blk[i]) pick_blk = enc_sel(i);
                    else        pick_sgl = enc_sel(i);
                end
            end
        end
    end

    always_comb begin
        if (rsv)                        sel = held;
        else if (full)                  sel = SEL_IDLE;
        else if (pick_blk != SEL_IDLE)  sel = pick_blk;
        else                            sel = pick_sgl;
    end

    assign taken_out = taken_in | (rsv ? '0 : sel_onehot(sel));

    assert_no_loopback_R2: assert property (@(posedge clk) disable iff (rst)
        sel_legal(OUT_IDX, sel));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (rsv && !$past(rst)) |-> (sel == $past(sel)));

    assert_skip_taken_R8: assert property (@(posedge clk) disable iff (rst)
        (!rsv && sel != SEL_IDLE) |-> ((taken_in & sel_onehot(sel)) == '0));

    assert_full_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (!rsv && full) |-> (sel == SEL_IDLE));

    assert_grant_requested_R10: assert property (@(posedge clk) disable iff (rst)
        (!rsv && sel != SEL_IDLE) |-> ((req & sel_onehot(sel)) != '0));

endmodule

// File: rtl/cpa_hold.sv
module cpa_hold
    import cpa_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_OUT-1:0][SEL_W-1:0] sel_d,
    output logic [N_OUT-1:0][SEL_W-1:0] sel_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int o = 0; o < N_OUT; o++) sel_q[o] <= SEL_IDLE;
        end else begin
            sel_q <= sel_d;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> (sel_q == '0));

endmodule

// File: rtl/cpa_arbiter.sv
module cpa_arbiter
    import cpa_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [N_OUT-1:0][N_IN-1:0]  req_i,
    input  logic [N_IN-1:0]             blk_i,
    input  logic [N_OUT-1:0]            rsv_i,
    input  logic [N_OUT-1:0]            full_i,
    output logic [N_OUT-1:0][SEL_W-1:0] sel_o
);

    logic [N_OUT-1:0][SEL_W-1:0] held;
    in_vec_t                     taken [N_OUT+1];
    in_vec_t                     held_busy;

    // Inputs pinned by reserved outputs are unavailable to every stage.
    always_comb begin
        held_busy = '0;
        for (int o = 0; o < N_OUT; o++) begin
            if (rsv_i[o]) held_busy = held_busy | sel_onehot(held[o]);
        end
    end

    assign taken[0] = held_busy;

    generate
        for (genvar o = 0; o < N_OUT; o++) begin : g_stage
            sel_t stage_sel;
            cpa_stage #(.OUT_IDX(o)) u_stage (
                .clk       (clk),
                .rst       (rst),
                .req       (req_i[o]),
                .blk       (blk_i),
                .rsv       (rsv_i[o]),
                .full      (full_i[o]),
                .held      (held[o]),
                .taken_in  (taken[o]),
                .sel       (stage_sel),
                .taken_out (taken[o+1])
            );
            assign sel_o[o] = stage_sel;
        end
    endgenerate

    cpa_hold u_hold (
        .clk   (clk),
        .rst   (rst),
        .sel_d (sel_o),
        .sel_q (held)
    );

    generate
        for (genvar i = 0; i < N_IN; i++) begin : g_excl
            logic [N_OUT-1:0] hit;
            always_comb begin
                for (int o = 0; o < N_OUT; o++) hit[o] = (sel_o[o] == enc_sel(i));
            end
            assert_single_grant_R6: assert property (@(posedge clk) disable iff (rst)
                $onehot0(hit));
        end
    endgenerate

endmodule

// File: tb/cpa_arbiter_tb.sv
module cpa_arbiter_tb;
    import cpa_pkg::*;

    typedef struct {
        logic [N_OUT-1:0][SEL_W-1:0] s;
        string                       tag;
    } item_t;

    logic                        clk = 1'b0;
    logic                        rst = 1'b1;
    logic [N_OUT-1:0][N_IN-1:0]  req_i = '0;
    logic [N_IN-1:0]             blk_i = '0;
    logic [N_OUT-1:0]            rsv_i = '0;
    logic [N_OUT-1:0]            full_i = '0;
    logic [N_OUT-1:0][SEL_W-1:0] sel_o;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    item_t q[$];
    logic [N_OUT-1:0][SEL_W-1:0] prev;

    // Ranks from R3, written as [output][input]; 15 means not allowed (R2).
    int rk [N_OUT][N_IN] = '{'{0, 15, 1, 2}, '{2, 0, 1, 3}, '{1, 0, 15, 2}};

    always #4 clk = ~clk;

    cpa_arbiter u_dut (
        .clk(clk), .rst(rst), .req_i(req_i), .blk_i(blk_i),
        .rsv_i(rsv_i), .full_i(full_i), .sel_o(sel_o)
    );

    task automatic step(input logic [3:0] r0, input logic [3:0] r1, input logic [3:0] r2,
                        input logic [3:0] b, input logic [2:0] rv, input logic [2:0] fl,
                        input string tag);
        item_t           it;
        logic [3:0]      tk;
        logic [3:0]      rq [3];
        @(posedge clk);
        #1;
        req_i  = {r2, r1, r0};
        blk_i  = b;
        rsv_i  = rv;
        full_i = fl;
        rq[0] = r0; rq[1] = r1; rq[2] = r2;
        tk = '0;
        for (int o = 0; o < 3; o++)
            if (rv[o] && prev[o] != 0) tk[prev[o]-1] = 1'b1;
        for (int o = 0; o < 3; o++) begin
            int best; int bestr; bit bestb;
            if (rv[o]) begin
                it.s[o] = prev[o];
            end else if (fl[o]) begin
                it.s[o] = 3'd0;
            end else begin
                best = -1; bestr = 99; bestb = 1'b0;
                for (int i = 0; i < 4; i++) begin
                    if (rq[o][i] && !tk[i] && rk[o][i] != 15) begin
                        if ((b[i] && !bestb) || (b[i] == bestb && rk[o][i] < bestr)) begin
                            best = i; bestr = rk[o][i]; bestb = b[i];
                        end
                    end
                end
                it.s[o] = (best < 0) ? 3'd0 : 3'(best + 1);
                if (best >= 0) tk[best] = 1'b1;
            end
        end
        it.tag = tag;
        prev = it.s;
        q.push_back(it);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                for (int o = 0; o < N_OUT; o++) begin
                    checks++;
                    if (sel_o[o] !== it.s[o]) begin
                        errors++;
                        $display("FAIL %s output %0d actual %0d expected %0d",
                                 it.tag, o, sel_o[o], it.s[o]);
                    end
                end
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        prev = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: idle after reset, and reserved outputs expose idle held selects
        step(4'h0, 4'h0, 4'h0, 4'h0, 3'b000, 3'b000, "R1");
        step(4'hF, 4'hF, 4'hF, 4'hF, 3'b111, 3'b000, "R1");
        // R3: ranking on each output
        step(4'hB, 4'h0, 4'h0, 4'h0, 3'b000, 3'b000, "R3");
        step(4'hC, 4'h0, 4'h0, 4'h0, 3'b000, 3'b000, "R3");
        step(4'h8, 4'h0, 4'h0, 4'h0, 3'b000, 3'b000, "R3");
        step(4'h0, 4'hF, 4'h0, 4'h0, 3'b000, 3'b000, "R3");
        step(4'h0, 4'hD, 4'h0, 4'h0, 3'b000, 3'b000, "R3");
        step(4'h0, 4'h9, 4'h0, 4'h0, 3'b000, 3'b000, "R3");
        step(4'h0, 4'h0, 4'hB, 4'h0, 3'b000, 3'b000, "R3");
        step(4'h0, 4'h0, 4'h9, 4'h0, 3'b000, 3'b000, "R3");
        // R2: no loopback
        step(4'h2, 4'h0, 4'h4, 4'h0, 3'b000, 3'b000, "R2");
        // R4: block service wins
        step(4'h9, 4'h0, 4'h0, 4'h8, 3'b000, 3'b000, "R4");
        step(4'h0, 4'hF, 4'h0, 4'h1, 3'b000, 3'b000, "R4");
        step(4'h5, 4'h0, 4'h0, 4'h5, 3'b000, 3'b000, "R4");
        // R5: cascade masking
        step(4'h1, 4'h1, 4'h0, 4'h0, 3'b000, 3'b000, "R5");
        step(4'h5, 4'h5, 4'h0, 4'h0, 3'b000, 3'b000, "R5");
        step(4'h1, 4'h3, 4'h3, 4'h0, 3'b000, 3'b000, "R5");
        // R6: everything requests everything
        step(4'hF, 4'hF, 4'hF, 4'h0, 3'b000, 3'b000, "R6");
        step(4'hF, 4'hF, 4'hF, 4'hF, 3'b000, 3'b000, "R6");
        // R7/R8: grant W on E, then reserve E while others compete
        step(4'h0, 4'h1, 4'h0, 4'h0, 3'b000, 3'b000, "R7");
        step(4'h5, 4'h2, 4'h1, 4'h2, 3'b010, 3'b010, "R8");
        step(4'h1, 4'hF, 4'h9, 4'hF, 3'b010, 3'b000, "R7");
        step(4'h0, 4'h0, 4'h0, 4'h0, 3'b000, 3'b000, "R7");
        // R9: full output skips, candidate flows downstream
        step(4'h1, 4'h1, 4'h0, 4'h0, 3'b000, 3'b001, "R9");
        step(4'h0, 4'h0, 4'h1, 4'h0, 3'b000, 3'b100, "R9");
        // R10: only requesters are granted, with no latency
        step(4'h0, 4'h0, 4'h0, 4'hF, 3'b000, 3'b000, "R10");
        step(4'h8, 4'h4, 4'h2, 4'h0, 3'b000, 3'b000, "R10");
        step(4'h0, 4'h0, 4'h0, 4'h0, 3'b000, 3'b000, "R10");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule